// File: doc/BRIEF.md
# Carrier Waveform Segment Player

The block plays a short list of 16-bit segment descriptors on one output pin, as an infrared transmitter needs. Each descriptor selects either a modulated burst or a silent gap, and gives its length as a whole number of carrier periods. The carrier is a square wave set by two values in clock ticks: a period `P` and a high-time compare value `C`. For example, a 38 kHz carrier at one-third duty uses `P` equal to the clock rate divided by 38 000, and `C` equal to `P/3`.

Software fills an internal queue through a simple write port while the block is idle, and then issues `start`. The block plays the descriptors in load order. When the last one has finished, it raises a sticky done flag. An interrupt is raised when the mask allows it, and software clears the flag by writing a 1. A `stop` command aborts playback at once and empties the queue. An `invert` input flips the pin, so that a complementary driver can feed the emitter.

The controller has three states. `ST_IDLE` waits for a start. `ST_RUN` plays segments. `ST_FINISH` is a single closing cycle. The transitions are as follows:
- `ST_IDLE` to `ST_RUN` on a start with a non-empty queue and no stop.
- `ST_RUN` to `ST_FINISH` when the last period of the last segment ends.
- `ST_RUN` to `ST_IDLE` on a stop.
- `ST_FINISH` to `ST_IDLE` always.

Top module: `seg_wave_player`

## Requirements
- R1: A descriptor holds the carrier-on flag in bit 15 and a period count `N` in bits 14:0. A segment lasts exactly `N*P` clock cycles. Segments follow each other with no gap, in the order they were loaded. The first segment begins in the clock cycle after the edge that accepted `start`.
- R2: Within a carrier-on segment, each period begins at phase zero, counted from the start of the segment. The output is active for the first `C` ticks of each `P`-tick period. When `C >= P` it is active for the whole period, and when `C = 0` it is never active. `P` and `C` are captured when `start` is accepted and held for the whole run.
- R3: During a carrier-off segment, and whenever the block is not busy, `wave_out` sits at its idle level, which equals `invert`.
- R4: With `invert=1` the pin is the complement of the non-inverted waveform at every cycle.
- R5: A write is accepted only when all of the following hold: the block is idle, the queue holds fewer than `DEPTH` entries, neither `start` nor `stop` is high in the same cycle, and the count field is non-zero. A zero-count descriptor is therefore dropped and adds no output time. `queue_len` reports the accepted descriptors, and `queue_bytes` always equals twice `queue_len`.
- R6: `start` with a non-empty queue raises `busy` in the next cycle. `start` with an empty queue has no effect.
- R7: After the last segment, `busy` stays high for one more cycle. It then falls, in the same cycle that `done_sts` rises and the queue empties.
- R8: `irq` equals `done_sts` AND `irq_mask`. A `done_clr` pulse clears `done_sts`. If a done event and `done_clr` fall in the same cycle, the flag ends up set.
- R9: `stop` has priority over `start`. One cycle after `stop`, the block is idle, the queue is empty, and `done_sts` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_data | input | 16 | Descriptor: bit 15 carrier on, bits 14:0 period count |
| start | input | 1 | Begin playback of the queue |
| stop | input | 1 | Abort playback and flush the queue |
| period | input | PER_W | Carrier period in clock ticks |
| compare | input | PER_W | Carrier high time in clock ticks |
| invert | input | 1 | Invert the output pin |
| irq_mask | input | 1 | Interrupt enable for the done flag |
| done_clr | input | 1 | Write-one-to-clear for the done flag |
| busy | output | 1 | Playback in progress |
| queue_len | output | $clog2(DEPTH)+1 | Descriptors held in the queue |
| queue_bytes | output | $clog2(DEPTH)+2 | Transfer length in bytes |
| wave_out | output | 1 | Modulated output pin |
| done_sts | output | 1 | Sticky done flag |
| irq | output | 1 | Masked done interrupt |

## Verification
The done event and a software clear of the done flag can land in the same clock cycle. The bench provokes this by raising `done_clr` during the `ST_FINISH` cycle of some runs, whose position it computes from the sum of `N*P` over the queue. It expects the flag to read 1 afterwards, then clears it with a separate pulse and expects 0. Start and stop given together, and a write given during playback, are also driven on purpose. In both cases the bench judges the result at `busy` and `queue_len`.

// File: rtl/swp_pkg.sv
package swp_pkg;
    localparam int DESC_W = 16;
    localparam int CNT_W  = DESC_W - 1;

    typedef struct packed {
        logic             on;
        logic [CNT_W-1:0] cnt;
    } seg_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH
    } play_state_t;
endpackage

// File: rtl/swp_desc_queue.sv
module swp_desc_queue #(
    parameter int DEPTH  = 8,
    parameter int DESC_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DESC_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DESC_W-1:0] head,
    output logic [AW:0]       count,
    output logic              more
);
    logic [DESC_W-1:0] mem [DEPTH];
    logic [AW:0]       wr_idx;
    logic [AW:0]       rd_idx;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx[AW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else if (flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (push) wr_idx <= wr_idx + 1'b1;
            if (pop)  rd_idx <= rd_idx + 1'b1;
        end
    end

    assign head  = mem[rd_idx[AW-1:0]];
    assign count = wr_idx;
    assign more  = (rd_idx != wr_idx);
endmodule

// File: rtl/swp_carrier_tick.sv
module swp_carrier_tick #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] per,
    input  logic [PER_W-1:0] cmp,
    output logic             period_end,
    output logic             carrier_hi
);
    logic [PER_W-1:0] phase;
    logic [PER_W-1:0] per_eff;

    assign per_eff    = (per == '0) ? PER_W'(1) : per;
    assign period_end = run && (phase == per_eff - PER_W'(1));
    assign carrier_hi = (phase < cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run || period_end) begin
            phase <= '0;
        end else begin
            phase <= phase + PER_W'(1);
        end
    end
endmodule

// File: rtl/seg_wave_player.sv
module seg_wave_player
    import swp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PER_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DESC_W-1:0] wr_data,
    input  logic              start,
    input  logic              stop,
    input  logic [PER_W-1:0]  period,
    input  logic [PER_W-1:0]  compare,
    input  logic              invert,
    input  logic              irq_mask,
    input  logic              done_clr,
    output logic              busy,
    output logic [AW:0]       queue_len,
    output logic [AW+1:0]     queue_bytes,
    output logic              wave_out,
    output logic              done_sts,
    output logic              irq
);
    play_state_t      state_q, state_d;
    seg_desc_t        head;
    logic [DESC_W-1:0] head_raw;
    logic             more;
    logic             period_end, carrier_hi;
    logic             seg_on_q;
    logic [CNT_W-1:0] dur_q;
    logic [PER_W-1:0] per_q, cmp_q;
    logic             done_q;

    logic             push, load_seg, flush, set_done, run, launch, seg_last;

    assign head     = seg_desc_t'(head_raw);
    assign push     = wr_en && (state_q == ST_IDLE) && !start && !stop
                      && (wr_data[CNT_W-1:0] != '0) && (queue_len != (AW+1)'(DEPTH));
    assign launch   = (state_q == ST_IDLE) && !stop && start && (queue_len != '0);
    assign seg_last = period_end && (dur_q == CNT_W'(1));

    swp_desc_queue #(.DEPTH(DEPTH), .DESC_W(DESC_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop       (load_seg),
        .flush     (flush),
        .head      (head_raw),
        .count     (queue_len),
        .more      (more)
    );

    swp_carrier_tick #(.PER_W(PER_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .per        (per_q),
        .cmp        (cmp_q),
        .period_end (period_end),
        .carrier_hi (carrier_hi)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_RUN;
            ST_RUN: begin
                if (stop)                   state_d = ST_IDLE;
                else if (seg_last && !more) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        run      = 1'b0;
        load_seg = 1'b0;
        flush    = stop;
        set_done = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_seg = launch;
            ST_RUN: begin
                run      = 1'b1;
                load_seg = !stop && seg_last && more;
            end
            ST_FINISH: begin
                flush    = 1'b1;
                set_done = !stop;
            end
            default: ;
        endcase
    end

    // segment datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_on_q <= 1'b0;
            dur_q    <= '0;
            per_q    <= PER_W'(1);
            cmp_q    <= '0;
        end else begin
            if (launch) begin
                per_q <= period;
                cmp_q <= compare;
            end
            if (load_seg) begin
                seg_on_q <= head.on;
                dur_q    <= head.cnt;
            end else if (run && period_end) begin
                dur_q <= dur_q - CNT_W'(1);
            end
        end
    end

    // sticky done flag, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (set_done) done_q <= 1'b1;
        else if (done_clr) done_q <= 1'b0;
    end

    assign busy        = (state_q != ST_IDLE);
    assign queue_bytes = {queue_len, 1'b0};
    assign wave_out    = ((state_q == ST_RUN) && seg_on_q && carrier_hi) ^ invert;
    assign done_sts    = done_q;
    assign irq         = done_q && irq_mask;
endmodule

// File: rtl/swp_player_chk.sv
module swp_player_chk #(
    parameter int DEPTH = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stop,
    input logic                     invert,
    input logic                     busy,
    input logic                     wave_out,
    input logic                     done_sts,
    input logic                     irq,
    input logic [$clog2(DEPTH):0]   queue_len
);
    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wave_out == invert));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_sts);

    // R5
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        queue_len <= ($clog2(DEPTH)+1)'(DEPTH));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(queue_len));

    // R9
    stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && queue_len == '0));

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_sts) |-> $fell(busy));
endmodule

bind seg_wave_player swp_player_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/seg_wave_player_test.sv
`timescale 1ns/100ps
module seg_wave_player_test;
    localparam int DEPTH = 8;
    localparam int PER_W = 16;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, start = 0, stop = 0, invert = 0, irq_mask = 0, done_clr = 0;
    logic [15:0] wr_data = '0;
    logic [PER_W-1:0] period = 16'd3, compare = 16'd1;
    logic busy, wave_out, done_sts, irq;
    logic [AW:0] queue_len;
    logic [AW+1:0] queue_bytes;

    always #2.5 clk = ~clk;

    seg_wave_player #(.DEPTH(DEPTH), .PER_W(PER_W)) uut (.*);

    int n_chk = 0, n_bad = 0;
    bit exp_on [DEPTH];
    int exp_cnt [DEPTH];
    int nseg = 0;

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int model(int k, int p, int c);
        int acc = 0;
        for (int i = 0; i < nseg; i++) begin
            int len;
            len = exp_cnt[i] * p;
            if (k < acc + len) return (exp_on[i] && ((k - acc) % p) < c) ? 1 : 0;
            acc += len;
        end
        return 0;
    endfunction

    // tasks begin and end just after a falling edge
    task automatic push(bit on, int cnt);
        wr_en = 1'b1;
        wr_data = {on, 15'(cnt)};
        @(negedge clk);
        wr_en = 1'b0;
        if (cnt != 0 && nseg < DEPTH) begin
            exp_on[nseg] = on;
            exp_cnt[nseg] = cnt;
            nseg++;
        end
    endtask

    task automatic play(int p, int c, bit inv, bit msk, bit clr_tail);
        int t = 0;
        for (int i = 0; i < nseg; i++) t += exp_cnt[i] * p;
        period = 16'(p); compare = 16'(c); invert = inv; irq_mask = msk;
        chk("R5 queue_len before run", int'(queue_len), nseg);
        chk("R5 queue_bytes before run", int'(queue_bytes), 2 * nseg);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        period = 16'($urandom % 7);
        compare = 16'($urandom % 7);
        chk("R6 busy after start", int'(busy), 1);
        for (int k = 0; k < t; k++) begin
            chk("R1 R2 R4 wave", int'(wave_out), model(k, p, c) ^ int'(inv));
            @(negedge clk);
        end
        chk("R7 busy in closing cycle", int'(busy), 1);
        chk("R7 done not yet set", int'(done_sts), 0);
        chk("R3 idle level in closing cycle", int'(wave_out), int'(inv));
        if (clr_tail) done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R7 busy low after finish", int'(busy), 0);
        chk("R7 R8 done set (set wins over clear)", int'(done_sts), 1);
        chk("R7 queue emptied", int'(queue_len), 0);
        chk("R8 irq masked", int'(irq), int'(msk));
        chk("R3 idle level after run", int'(wave_out), int'(inv));
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R8 done cleared", int'(done_sts), 0);
        chk("R8 irq cleared", int'(irq), 0);
        nseg = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung run expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset busy", int'(busy), 0);
        chk("R8 reset done", int'(done_sts), 0);
        chk("R8 reset irq", int'(irq), 0);
        chk("R5 reset queue_len", int'(queue_len), 0);
        chk("R3 reset idle level", int'(wave_out), 0);

        // empty start with a simultaneous write: both have no effect
        start = 1'b1; wr_en = 1'b1; wr_data = 16'h8003;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        chk("R6 empty start stays idle", int'(busy), 0);
        chk("R5 write beside start rejected", int'(queue_len), 0);

        // zero count dropped
        push(1'b1, 0);
        chk("R5 zero count dropped", int'(queue_len), 0);

        // overfill then flush with stop while idle
        for (int i = 0; i < DEPTH + 1; i++) push(1'b1, 1);
        chk("R5 full queue holds DEPTH", int'(queue_len), DEPTH);
        chk("R5 bytes at full", int'(queue_bytes), 2 * DEPTH);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R9 idle stop flushes", int'(queue_len), 0);
        nseg = 0;

        // directed: full-on, off, never-on carriers
        push(1'b1, 2); push(1'b0, 1); push(1'b1, 3);
        play(4, 4, 1'b0, 1'b1, 1'b1);
        push(1'b1, 2); push(1'b1, 1);
        play(3, 0, 1'b1, 1'b0, 1'b0);
        push(1'b1, 1);
        play(1, 1, 1'b0, 1'b1, 1'b0);

        // stop during playback, write during playback
        push(1'b1, 4); push(1'b0, 4); push(1'b1, 4);
        period = 16'd3; compare = 16'd2; invert = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b1; wr_data = 16'h8002;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 write while busy rejected", int'(queue_len), 3);
        chk("R6 busy during run", int'(busy), 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R9 stop ends run", int'(busy), 0);
        chk("R9 stop empties queue", int'(queue_len), 0);
        chk("R9 stop leaves done", int'(done_sts), 0);
        chk("R3 R4 idle level after stop", int'(wave_out), 1);
        repeat (5) @(negedge clk);
        chk("R9 no late done", int'(done_sts), 0);
        nseg = 0;

        // start and stop together: stop wins
        push(1'b1, 2);
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk("R9 stop beats start busy", int'(busy), 0);
        chk("R9 stop beats start queue", int'(queue_len), 0);
        nseg = 0;

        // constrained random runs
        for (int r = 0; r < 30; r++) begin
            int n, p, c;
            n = 1 + int'($urandom % DEPTH);
            for (int i = 0; i < n; i++) push(1'($urandom % 2), 1 + int'($urandom % 4));
            p = 1 + int'($urandom % 5);
            c = int'($urandom % (p + 2));
            play(p, c, 1'(r % 2), 1'($urandom % 2), (r % 3) == 0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule